// File: doc/BRIEF.md
# Comma-Aligning Serial-to-Word Receiver

This block sits behind a clock/data recovery stage and runs on the recovered bit clock. On every rising edge it accepts one serial bit. A loopback select chooses whether that bit comes from the line input or from the local loopback input. The block packs the bits into 10-bit words. The first bit of a word lands in bit 9 and the last bit lands in bit 0. Each finished word is handed on with a one-cycle word strobe.

When alignment is enabled, a 10-bit sliding window is compared against both running-disparity forms of the K28.5 comma on every bit. A match ends the current word at once. The comma is delivered as a whole word and a sync flag is raised in that same strobe cycle. The word boundary is re-phased so that the next word starts with the bit after the comma. Any partial word that was in progress is dropped. When alignment is disabled, commas pass through like any other data and the boundary never moves.

Top module: `comma_align_rx`

## Requirements
- R1: Bits are taken one per clock edge. The first bit of a word appears on wordOut[9] and the tenth on wordOut[0].
- R2: Without realignment, wordStrobe pulses for exactly one cycle after every 10th bit, and wordOut holds its value between strobes.
- R3: With syncEnable high, the patterns 0011111010 and 1100000101 (bit 9 down to bit 0) are detected at any bit offset. The matched pattern is emitted as a whole word, and the next word starts with the following bit.
- R4: syncFlag is high only in a cycle where wordStrobe is high and wordOut holds one of the two comma patterns.
- R5: A comma that already sits on the current word boundary raises syncFlag and leaves the strobe spacing at 10 cycles.
- R6: A realignment that cuts the current word short emits no strobe for the partial word. The comma strobe follows the previous strobe after fewer than 10 cycles.
- R7: With syncEnable low, syncFlag stays low and a comma at any offset leaves the word boundary unchanged.
- R8: loopSel=1 takes the bits from serLoop and loopSel=0 takes them from serNormal. The unselected input has no effect on wordOut.
- R9: While rstN is low, wordOut is 0 and wordStrobe and syncFlag are low. After reset, the first strobe follows the tenth received bit, and bits held over from before reset never form a comma match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one serial bit per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serNormal | input | 1 | Serial bit from the line input |
| serLoop | input | 1 | Serial bit from the loopback input |
| loopSel | input | 1 | 1 selects serLoop, 0 selects serNormal |
| syncEnable | input | 1 | Enables comma search and word realignment |
| wordOut | output | 10 | Assembled word, first received bit in bit 9 |
| syncFlag | output | 1 | High in the strobe cycle of a comma word |
| wordStrobe | output | 1 | One-cycle pulse when wordOut is updated |

## Verification
The stream starts three bits off the word boundary, so a single comma must pull the phase into line. The strobe gap is measured at that point. A design that still emitted the three-bit partial word, or that missed the comma, would show a wrong gap or a garbled word. Aligned commas of both polarities check that the sync flag rises without moving the phase. A misaligned comma sent while alignment is disabled must come out split across two ordinary words, with no flag. During the loopback section the unused input carries the complement of the data, so a swapped select corrupts every word.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

  localparam int unsigned SYM_W   = 10;
  localparam int unsigned N_COMMA = 2;

  // Both running-disparity forms of the K28.5 comma, bit 9 down to bit 0
  localparam logic [SYM_W-1:0] COMMA_SET [N_COMMA] = '{
    10'b0011111010,
    10'b1100000101
  };

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWord;   // capture the window into the output register
    logic markSync;   // the captured word is a comma
  } alignCtrl_t;

endpackage

// File: rtl/comma_align_dp.sv
module comma_align_dp
  import comma_align_pkg::*;
#(
  parameter int unsigned WORD_W = SYM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serNormal,
  input  logic              serLoop,
  input  logic              loopSel,
  input  alignCtrl_t        ctrl,
  output logic              commaSeen,
  output logic [WORD_W-1:0] wordOut,
  output logic              syncFlag,
  output logic              wordStrobe
);

  logic              serBit;
  logic [WORD_W-1:0] window;
  logic [N_COMMA-1:0] matchVec;

  assign serBit = loopSel ? serLoop : serNormal;

  // Sliding window: the oldest bit sits in the MSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) window <= '0;
    else       window <= {window[WORD_W-2:0], serBit};
  end

  // One comparator per comma form
  for (genvar gi = 0; gi < N_COMMA; gi++) begin : g_cmp
    assign matchVec[gi] = (window == COMMA_SET[gi]);
  end

  assign commaSeen = |matchVec;

  // Output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut    <= '0;
      syncFlag   <= 1'b0;
      wordStrobe <= 1'b0;
    end else begin
      wordStrobe <= ctrl.loadWord;
      syncFlag   <= ctrl.loadWord & ctrl.markSync;
      if (ctrl.loadWord) wordOut <= window;
    end
  end

  AST_SYNC_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    syncFlag |-> wordStrobe); // R4

  AST_SYNC_IS_COMMA: assert property (@(posedge clk) disable iff (!rstN)
    syncFlag |-> (wordOut == COMMA_SET[0] || wordOut == COMMA_SET[1])); // R4

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wordStrobe |-> $stable(wordOut)); // R2

endmodule

// File: rtl/comma_align_ctrl.sv
module comma_align_ctrl
  import comma_align_pkg::*;
#(
  parameter int unsigned WORD_W = SYM_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncEnable,
  input  logic       commaSeen,
  output alignCtrl_t ctrl
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0] bitCnt;   // bits of the current word held in the window
  logic             primed;   // window holds WORD_W post-reset bits
  logic             wordFull;
  logic             commaHit;

  assign wordFull = (bitCnt == CNT_W'(WORD_W));
  assign commaHit = primed & syncEnable & commaSeen;

  always_comb begin
    ctrl          = '0;
    ctrl.loadWord = wordFull | commaHit;
    ctrl.markSync = commaHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      primed <= 1'b0;
    end else begin
      if (bitCnt == CNT_W'(WORD_W - 1)) primed <= 1'b1;
      if (ctrl.loadWord) bitCnt <= CNT_W'(1);
      else               bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(WORD_W)); // R2

  AST_FULL_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    wordFull |=> (bitCnt == CNT_W'(1))); // R2

  AST_NO_LOAD_UNPRIMED: assert property (@(posedge clk) disable iff (!rstN)
    !primed |-> !ctrl.loadWord); // R9

endmodule

// File: rtl/comma_align_rx.sv
module comma_align_rx
  import comma_align_pkg::*;
#(
  parameter int unsigned WORD_W = SYM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serNormal,
  input  logic              serLoop,
  input  logic              loopSel,
  input  logic              syncEnable,
  output logic [WORD_W-1:0] wordOut,
  output logic              syncFlag,
  output logic              wordStrobe
);

  alignCtrl_t ctrl;
  logic       commaSeen;

  comma_align_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncEnable (syncEnable),
    .commaSeen  (commaSeen),
    .ctrl       (ctrl)
  );

  comma_align_dp #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .serNormal  (serNormal),
    .serLoop    (serLoop),
    .loopSel    (loopSel),
    .ctrl       (ctrl),
    .commaSeen  (commaSeen),
    .wordOut    (wordOut),
    .syncFlag   (syncFlag),
    .wordStrobe (wordStrobe)
  );

  AST_NO_SYNC_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(syncEnable) |-> !syncFlag); // R7

endmodule

// File: tb/comma_align_rx_bench.sv
`timescale 1ns/1ps
module comma_align_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serNormal = 1'b0;
  logic       serLoop = 1'b1;
  logic       loopSel = 1'b0;
  logic       syncEnable = 1'b1;
  logic [9:0] wordOut;
  logic       syncFlag;
  logic       wordStrobe;

  always #2 clk = ~clk;

  comma_align_rx u_comma_align_rx (
    .clk(clk), .rstN(rstN), .serNormal(serNormal), .serLoop(serLoop),
    .loopSel(loopSel), .syncEnable(syncEnable),
    .wordOut(wordOut), .syncFlag(syncFlag), .wordStrobe(wordStrobe)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;
  int cycle = 0;

  always @(posedge clk) cycle <= cycle + 1;

  // Captured words
  logic [9:0] capW [40];
  logic       capS [40];
  int         capT [40];
  int         capN = 0;

  always @(negedge clk) begin
    if (rstN && wordStrobe && capN < 40) begin
      capW[capN] = wordOut;
      capS[capN] = syncFlag;
      capT[capN] = cycle;
      capN = capN + 1;
    end
  end

  // Expected words
  logic [9:0] expW [40];
  logic       expS [40];
  string      expR [40];
  int         expN = 0;

  task automatic pushExp(input logic [9:0] w, input logic s, input string r);
    expW[expN] = w; expS[expN] = s; expR[expN] = r; expN++;
  endtask

  task automatic check(input bit ok, input string r, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // Drive one bit on the selected line, complement on the other
  task automatic sendBit(input logic b);
    if (loopSel) begin serLoop = b; serNormal = ~b; end
    else         begin serNormal = b; serLoop = ~b; end
    @(negedge clk);
  endtask

  task automatic sendBits(input logic [9:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  // {word, expected sync}
  localparam logic [10:0] VEC [8] = '{
    {10'b0011111010, 1'b1},
    {10'b1010101010, 1'b0},
    {10'b0110011001, 1'b0},
    {10'b1100000101, 1'b1},
    {10'b1001100110, 1'b0},
    {10'b0101010101, 1'b0},
    {10'b0011111010, 1'b1},
    {10'b1100110011, 1'b0}
  };

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check(wordOut == 10'd0, "R9", "reset wordOut", wordOut, 0);
    check(!wordStrobe, "R9", "reset wordStrobe", wordStrobe, 0);
    check(!syncFlag, "R9", "reset syncFlag", syncFlag, 0);
    rstN = 1'b1;

    // Three bits off-boundary, then the vector table
    sendBits(10'b101, 3);
    pushExp(10'b1010011111, 1'b0, "R9");
    for (int i = 0; i < 8; i++) begin
      sendBits(VEC[i][10:1], 10);
      pushExp(VEC[i][10:1], VEC[i][0], (i == 0) ? "R3" : (VEC[i][0] ? "R5" : "R1"));
    end

    // R7: misaligned comma while disabled
    syncEnable = 1'b0;
    sendBits(10'b10, 2);
    sendBits(10'b0011111010, 10);
    sendBits(10'b10101010, 8);
    pushExp(10'b1000111110, 1'b0, "R7");
    pushExp(10'b1010101010, 1'b0, "R7");

    // R6/R3: misaligned comma with alignment on
    syncEnable = 1'b1;
    sendBits(10'b0110, 4);
    sendBits(10'b1100000101, 10);
    pushExp(10'b0110110000, 1'b0, "R6");
    pushExp(10'b1100000101, 1'b1, "R3");

    // R8: loopback path
    loopSel = 1'b1;
    sendBits(10'b0110011001, 10);
    sendBits(10'b1001100110, 10);
    pushExp(10'b0110011001, 1'b0, "R8");
    pushExp(10'b1001100110, 1'b0, "R8");

    loopSel = 1'b0;
    sendBits(10'b1010101010, 10);
    sendBits(10'b0101010101, 10);
    pushExp(10'b1010101010, 1'b0, "R8");
    pushExp(10'b0101010101, 1'b0, "R1");
    for (int i = 0; i < 8; i++) sendBit(1'b1);

    check(capN == expN, "R2", "strobe count", capN, expN);
    for (int i = 0; i < expN; i++) begin
      if (i < capN) begin
        check(capW[i] == expW[i], expR[i], $sformatf("word %0d", i), capW[i], expW[i]);
        check(capS[i] == expS[i], (expS[i] ? "R4" : expR[i]),
              $sformatf("sync %0d", i), capS[i], expS[i]);
      end
    end
    if (capN >= 13) begin
      check(capT[1] - capT[0] == 3, "R6", "gap before first comma", capT[1] - capT[0], 3);
      check(capT[2] - capT[1] == 10, "R2", "gap after comma", capT[2] - capT[1], 10);
      check(capT[4] - capT[3] == 10, "R5", "gap at aligned comma", capT[4] - capT[3], 10);
      check(capT[10] - capT[9] == 10, "R7", "gap with disabled comma", capT[10] - capT[9], 10);
      check(capT[12] - capT[11] == 4, "R6", "gap at short word", capT[12] - capT[11], 4);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R2: watchdog expired actual=%0d expected=%0d", capN, expN);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule